// File: doc/BRIEF.md
# Prefetch Queue Tracker with Address Pairing

This block keeps a shadow copy of a processor's instruction prefetch queue so that a bus analyzer can record the bytes the processor actually executes instead of the raw code fetches it makes. Each code-fetch byte seen on the bus goes into a local FIFO and produces no output. The processor reports its queue activity on a 2-bit status code. When that code says a byte was taken for execution, the tracker pops the oldest byte, pairs it with the value of its own address counter, and presents the pair for one cycle behind a strobe.

A program transfer reported on the status code discards every prefetched byte that has not been executed. The next code fetch after that supplies a fresh starting address, which is loaded into the counter. From then on the counter steps by one for each executed byte. The address counter is built from cascaded synchronous slices, and its width, the slice width, the byte width and the queue depth are all parameters.

Top module: `pqt_tracker`

## Requirements
- R1: After reset, `exec_vld` and `underflow` are 0 and the local queue is empty.
- R2: A cycle with `fetch_vld` high and queue status other than 2'b10 writes `fetch_byte` into the queue and does not raise `exec_vld` in the next cycle.
- R3: Queue status 2'b01 (first byte) or 2'b11 (subsequent byte) on a non-empty queue pops the oldest byte. `exec_vld` is high in the following cycle, with `exec_byte` equal to that byte. Bytes come out in fetch order.
- R4: `exec_addr` carries the counter value at the time of the pop, and the counter then increments by one, so consecutive executed bytes carry consecutive addresses.
- R5: `exec_first` is 1 when the pop came from status 2'b01 and 0 when it came from status 2'b11.
- R6: Queue status 2'b10 (program transfer) empties the queue. A fetch in the same cycle is discarded.
- R7: The first fetch after reset or after a program transfer loads its `fetch_addr` into the counter. `fetch_addr` on all later fetches is ignored.
- R8: A fetch and a pop in the same cycle both take effect: the oldest byte comes out, the new byte is stored, and the occupancy is unchanged.
- R9: A pop request on an empty queue produces no strobe and sets `underflow`, which stays at 1 until reset.
- R10: When the queue holds DEPTH (16) bytes and no pop occurs in the same cycle, a further fetch is dropped.
- R11: Queue status 2'b00 changes neither the queue nor the counter, and raises no strobe.
- R12: The address counter wraps from 2^ADDR_W-1 (20'hFFFFF) to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_vld | input | 1 | A code-fetch byte is on the bus this cycle |
| fetch_addr | input | ADDR_W (20) | Address of the code fetch |
| fetch_byte | input | DATA_W (8) | Fetched byte |
| qstat | input | 2 | Queue status: 00 idle, 01 first byte, 10 program transfer, 11 subsequent byte |
| exec_vld | output | 1 | One-cycle strobe for an executed byte |
| exec_byte | output | DATA_W (8) | Executed byte |
| exec_addr | output | ADDR_W (20) | Address paired with the executed byte |
| exec_first | output | 1 | Executed byte was reported as a first byte |
| underflow | output | 1 | Sticky flag: a pop was requested on an empty queue |

## Verification
The main function is driven with separated fetch-then-execute bursts, interleaved idle codes, and fetches issued in the same cycle as pops. Comparing these patterns separates byte order and occupancy from address pairing. Flush patterns include a fetch in the flush cycle itself and fetches with misleading addresses after a reload. They show whether the dropped byte and the ignored addresses leak into the output. A fill to 17 bytes, followed by a drain until underflow, marks the exact depth boundary. A reload just below the counter's top shows whether the carry chain wraps across every slice.

// File: rtl/pqt_pkg.sv
package pqt_pkg;
   typedef enum logic [1:0] {
      QS_IDLE  = 2'b00,
      QS_FIRST = 2'b01,
      QS_FLUSH = 2'b10,
      QS_NEXT  = 2'b11
   } qstat_e;
endpackage

// File: rtl/pqt_fifo.sv
module pqt_fifo #(
   parameter int DEPTH  = 16,
   parameter int DATA_W = 8,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_en,
   output logic [DATA_W-1:0] rd_data,
   output logic              empty,
   output logic              full,
   output logic [CNT_W-1:0]  count
);
   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("pqt_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wr_ptr, rd_ptr;
   logic              do_wr, do_rd;

   assign empty   = (count == '0);
   assign full    = (count == CNT_W'(DEPTH));
   assign do_rd   = rd_en && !empty && !clr;
   assign do_wr   = wr_en && !clr && (!full || do_rd);
   assign rd_data = mem[rd_ptr];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wr_ptr] <= wr_data;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_wr) wr_ptr <= wr_ptr + 1'b1;
         if (do_rd) rd_ptr <= rd_ptr + 1'b1;
         count <= count + CNT_W'(do_wr) - CNT_W'(do_rd);
      end
   end
endmodule

// File: rtl/pqt_addr_ctr.sv
module pqt_addr_ctr #(
   parameter int ADDR_W  = 20,
   parameter int SLICE_W = 4,
   localparam int NSL    = ADDR_W / SLICE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              inc,
   output logic [ADDR_W-1:0] value
);
   generate
      if (SLICE_W < 1 || (ADDR_W % SLICE_W) != 0) begin : g_bad_slice
         $error("pqt_addr_ctr: ADDR_W must be a multiple of SLICE_W");
      end
   endgenerate

   logic [NSL:0] carry;
   assign carry[0] = inc;

   for (genvar g = 0; g < NSL; g++) begin : g_slice
      logic [SLICE_W-1:0] q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            q <= '0;
         else if (load)
            q <= load_val[g*SLICE_W +: SLICE_W];
         else if (carry[g])
            q <= q + 1'b1;
      end
      assign carry[g+1] = carry[g] && (&q);
      assign value[g*SLICE_W +: SLICE_W] = q;
   end
endmodule

// File: rtl/pqt_tracker.sv
module pqt_tracker
   import pqt_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 8,
   parameter int DEPTH   = 16,
   parameter int SLICE_W = 4,
   localparam int CNT_W  = $clog2(DEPTH) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fetch_vld,
   input  logic [ADDR_W-1:0] fetch_addr,
   input  logic [DATA_W-1:0] fetch_byte,
   input  logic [1:0]        qstat,
   output logic              exec_vld,
   output logic [DATA_W-1:0] exec_byte,
   output logic [ADDR_W-1:0] exec_addr,
   output logic              exec_first,
   output logic              underflow
);
   qstat_e            qs;
   logic              is_flush, pop_req, do_pop, do_load;
   logic              reload_pend;
   logic [DATA_W-1:0] q_head;
   logic              q_empty, q_full;
   logic [CNT_W-1:0]  q_count;
   logic [ADDR_W-1:0] ctr_val;

   assign qs       = qstat_e'(qstat);
   assign is_flush = (qs == QS_FLUSH);
   assign pop_req  = (qs == QS_FIRST) || (qs == QS_NEXT);
   assign do_pop   = pop_req && !q_empty;
   assign do_load  = fetch_vld && reload_pend && !is_flush;

   pqt_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_fifo (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (is_flush),
      .wr_en   (fetch_vld),
      .wr_data (fetch_byte),
      .rd_en   (pop_req),
      .rd_data (q_head),
      .empty   (q_empty),
      .full    (q_full),
      .count   (q_count)
   );

   pqt_addr_ctr #(.ADDR_W(ADDR_W), .SLICE_W(SLICE_W)) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (do_load),
      .load_val (fetch_addr),
      .inc      (do_pop),
      .value    (ctr_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)
         reload_pend <= 1'b1;
      else if (is_flush)
         reload_pend <= 1'b1;
      else if (do_load)
         reload_pend <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         exec_vld   <= 1'b0;
         exec_byte  <= '0;
         exec_addr  <= '0;
         exec_first <= 1'b0;
         underflow  <= 1'b0;
      end else begin
         exec_vld <= do_pop;
         if (do_pop) begin
            exec_byte  <= q_head;
            exec_addr  <= ctr_val;
            exec_first <= (qs == QS_FIRST);
         end
         if (pop_req && q_empty) underflow <= 1'b1;
      end
   end
endmodule

// File: rtl/pqt_tracker_chk.sv
module pqt_tracker_chk #(
   parameter int ADDR_W  = 20,
   parameter int DEPTH   = 16,
   localparam int CNT_W  = $clog2(DEPTH) + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              fetch_vld,
   input logic [1:0]        qstat,
   input logic              exec_vld,
   input logic [ADDR_W-1:0] exec_addr,
   input logic              underflow,
   input logic [CNT_W-1:0]  q_count,
   input logic              q_empty,
   input logic              q_full
);
   logic pop_code;
   assign pop_code = (qstat == 2'b01) || (qstat == 2'b11);

   p_strobe_from_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
      exec_vld |-> ($past(qstat) == 2'b01 || $past(qstat) == 2'b11));

   p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_vld && $past(exec_vld)) |-> (exec_addr == $past(exec_addr) + ADDR_W'(1)));

   p_flush_empties_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (qstat == 2'b10) |=> q_empty);

   p_level_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_vld && pop_code && !q_empty && !q_full) |=> $stable(q_count));

   p_no_strobe_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (pop_code && q_empty) |=> (!exec_vld && underflow));

   p_underflow_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      underflow |=> underflow);

   p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
      q_count <= CNT_W'(DEPTH));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (qstat == 2'b00 && !fetch_vld) |=> (!exec_vld && $stable(q_count)));
endmodule

bind pqt_tracker pqt_tracker_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .fetch_vld (fetch_vld),
   .qstat     (qstat),
   .exec_vld  (exec_vld),
   .exec_addr (exec_addr),
   .underflow (underflow),
   .q_count   (q_count),
   .q_empty   (q_empty),
   .q_full    (q_full)
);

// File: tb/pqt_tracker_tb.sv
module pqt_tracker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        fetch_vld = 1'b0;
   logic [19:0] fetch_addr = '0;
   logic [7:0]  fetch_byte = '0;
   logic [1:0]  qstat = 2'b00;
   logic        exec_vld, exec_first, underflow;
   logic [7:0]  exec_byte;
   logic [19:0] exec_addr;
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   pqt_tracker u_dut (
      .clk(clk), .rst_n(rst_n), .fetch_vld(fetch_vld), .fetch_addr(fetch_addr),
      .fetch_byte(fetch_byte), .qstat(qstat), .exec_vld(exec_vld),
      .exec_byte(exec_byte), .exec_addr(exec_addr), .exec_first(exec_first),
      .underflow(underflow)
   );

   task automatic step(input logic fv, input logic [19:0] fa, input logic [7:0] fb,
                       input logic [1:0] qs);
      fetch_vld = fv; fetch_addr = fa; fetch_byte = fb; qstat = qs;
      @(posedge clk);
      @(negedge clk);
      fetch_vld = 1'b0; qstat = 2'b00;
   endtask

   task automatic expect_out(input logic ev, input logic [7:0] eb, input logic [19:0] ea,
                             input logic ef, input string tag);
      checks++;
      if (exec_vld !== ev ||
          (ev && (exec_byte !== eb || exec_addr !== ea || exec_first !== ef))) begin
         fails++;
         $display("FAIL %s: got vld=%0b byte=%h addr=%h first=%0b, expected vld=%0b byte=%h addr=%h first=%0b",
                  tag, exec_vld, exec_byte, exec_addr, exec_first, ev, eb, ea, ef);
      end
   endtask

   task automatic expect_uf(input logic eu, input string tag);
      checks++;
      if (underflow !== eu) begin
         fails++;
         $display("FAIL %s: got underflow=%0b, expected %0b", tag, underflow, eu);
      end
   endtask

   task automatic t_reset;
      expect_out(1'b0, 8'h00, 20'h0, 1'b0, "R1 strobe low after reset");
      expect_uf(1'b0, "R1 underflow clear after reset");
   endtask

   task automatic t_basic;
      step(1'b1, 20'h12340, 8'hA1, 2'b00);
      expect_out(1'b0, 8'h00, 20'h0, 1'b0, "R2 fetch not forwarded");
      step(1'b1, 20'h99999, 8'hB2, 2'b00);
      step(1'b1, 20'h55555, 8'hC3, 2'b00);
      expect_out(1'b0, 8'h00, 20'h0, 1'b0, "R2 fetch not forwarded");
      step(1'b0, 20'h0, 8'h00, 2'b01);
      expect_out(1'b1, 8'hA1, 20'h12340, 1'b1, "R3 R5 R7 first pop");
      step(1'b0, 20'h0, 8'h00, 2'b11);
      expect_out(1'b1, 8'hB2, 20'h12341, 1'b0, "R3 R4 R5 next pop");
      step(1'b0, 20'h0, 8'h00, 2'b00);
      expect_out(1'b0, 8'h00, 20'h0, 1'b0, "R11 idle no strobe");
      step(1'b0, 20'h0, 8'h00, 2'b11);
      expect_out(1'b1, 8'hC3, 20'h12342, 1'b0, "R11 R4 pop after idle");
   endtask

   task automatic t_flush;
      for (int i = 0; i < 4; i++) step(1'b1, 20'h60000 + 20'(i), 8'h10 + 8'(i), 2'b00);
      step(1'b0, 20'h0, 8'h00, 2'b01);
      expect_out(1'b1, 8'h10, 20'h12343, 1'b1, "R7 addr ignored without flush");
      step(1'b1, 20'h77777, 8'hEE, 2'b10);
      expect_out(1'b0, 8'h00, 20'h0, 1'b0, "R6 flush no strobe");
      step(1'b1, 20'h0ABCD, 8'h5A, 2'b00);
      step(1'b0, 20'h0, 8'h00, 2'b01);
      expect_out(1'b1, 8'h5A, 20'h0ABCD, 1'b1, "R6 R7 queue emptied and reload");
   endtask

   task automatic t_simul;
      step(1'b0, 20'h0, 8'h00, 2'b10);
      step(1'b1, 20'h40000, 8'h11, 2'b00);
      step(1'b1, 20'h40555, 8'h22, 2'b01);
      expect_out(1'b1, 8'h11, 20'h40000, 1'b1, "R8 pop with fetch");
      step(1'b0, 20'h0, 8'h00, 2'b11);
      expect_out(1'b1, 8'h22, 20'h40001, 1'b0, "R8 fetched byte kept");
      step(1'b0, 20'h0, 8'h00, 2'b00);
      expect_uf(1'b0, "R9 no false underflow");
   endtask

   task automatic t_wrap;
      step(1'b0, 20'h0, 8'h00, 2'b10);
      step(1'b1, 20'hFFFFF, 8'h31, 2'b00);
      step(1'b1, 20'h12345, 8'h32, 2'b00);
      step(1'b0, 20'h0, 8'h00, 2'b01);
      expect_out(1'b1, 8'h31, 20'hFFFFF, 1'b1, "R12 top address");
      step(1'b0, 20'h0, 8'h00, 2'b11);
      expect_out(1'b1, 8'h32, 20'h00000, 1'b0, "R12 wrap to zero");
   endtask

   task automatic t_full;
      step(1'b0, 20'h0, 8'h00, 2'b10);
      for (int i = 0; i < 17; i++) step(1'b1, 20'h20000, 8'h80 + 8'(i), 2'b00);
      for (int i = 0; i < 16; i++) begin
         step(1'b0, 20'h0, 8'h00, (i == 0) ? 2'b01 : 2'b11);
         expect_out(1'b1, 8'h80 + 8'(i), 20'h20000 + 20'(i), (i == 0),
                    "R10 R3 drain of full queue");
      end
   endtask

   task automatic t_underflow;
      step(1'b0, 20'h0, 8'h00, 2'b11);
      expect_out(1'b0, 8'h00, 20'h0, 1'b0, "R10 R9 seventeenth byte dropped");
      expect_uf(1'b1, "R9 underflow set");
      step(1'b0, 20'h0, 8'h00, 2'b00);
      step(1'b1, 20'h0, 8'h44, 2'b00);
      step(1'b0, 20'h0, 8'h00, 2'b01);
      expect_out(1'b1, 8'h44, 20'h20010, 1'b1, "R9 normal pop after underflow");
      expect_uf(1'b1, "R9 underflow sticky");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_flush();
      t_simul();
      t_wrap();
      t_full();
      t_underflow();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end
endmodule